// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This unit executes one family of multiply operations that return only the upper half of a signed product. Each request carries a 32-bit instruction word and three 32-bit operands: a multiplicand, a multiplier and an accumulator. The unit forms the full signed 64-bit product of the first two operands. It can then fold in the accumulator, aligned to the upper word, by addition or by subtraction. It can also add a half-unit bias that turns truncation into round-to-nearest. The upper 32 bits of the result are returned together with the destination register index taken from the instruction word.

Requests enter through a valid/ready handshake. Results leave through a valid-qualified output that honours a ready signal from downstream. The datapath has two register stages. The product is formed in the first stage, and the accumulate, round and upper-word select happen in the second, so results come out in issue order. Condition evaluation lives outside the block. A separate condition-pass input tells the unit whether a conditional instruction may write its destination. All 64-bit arithmetic wraps, with no saturation and no flags.

Top module: `smmw_mac`

## Requirements
- R1: A synchronous active-high reset clears both pipeline stages, so `out_valid` is 0 in the first cycle after reset.
- R2: When instruction bits [15:12] equal 15, the result is bits [63:32] of the signed 64-bit product of `in_mcand` and `in_mplier`, and `in_acc` has no effect on it.
- R3: When bits [15:12] are not 15 and bit 6 is 0, the result is bits [63:32] of (`in_acc` shifted left by 32) plus the product, modulo 2^64.
- R4: When bits [15:12] are not 15 and bit 6 is 1, the result is bits [63:32] of (`in_acc` shifted left by 32) minus the product, modulo 2^64.
- R5: When bit 5 is 1, 0x80000000 is added to the 64-bit intermediate before the upper word is taken.
- R6: `out_rd` carries instruction bits [19:16] of the same request.
- R7: `out_we` is 1 when instruction bits [31:28] equal 0xE. For any other value of that field it follows `in_cond_ok` as sampled with the request.
- R8: When downstream is ready, a request accepted on one clock edge appears on the output after the second clock edge that follows, and not after the first.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output holds its data and `in_ready` is 0. Results already in flight leave in issue order once the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request this cycle |
| in_insn | input | 32 | Instruction word |
| in_mcand | input | 32 | Multiplicand operand |
| in_mplier | input | 32 | Multiplier operand |
| in_acc | input | 32 | Accumulator operand |
| in_cond_ok | input | 1 | External condition-pass indication |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 32 | Upper word of the final intermediate |
| out_rd | output | 4 | Destination register index |
| out_we | output | 1 | Destination write permitted |

## Verification
The assertions assume that downstream drops `out_ready` only while it really intends to stall. They also assume that `in_valid` with its payload is held steady within a cycle and changes only away from the active edge. The bench drives every input on the falling edge and keeps `out_ready` high except in one deliberate stall sequence. In that sequence it holds the next request on the inputs so that the hold and in-order properties can be seen. The operand sweep pairs every signed corner value (zero, ±1, the most positive and most negative values) with every variant and with both condition outcomes.

// File: rtl/smmw_pkg.sv
package smmw_pkg;
    localparam logic [3:0] COND_ALWAYS = 4'hE;
    localparam logic [3:0] NO_ACC_IDX  = 4'hF;

    typedef struct packed {
        logic [3:0] rd;
        logic       accumulate;
        logic       subtract;
        logic       round;
        logic       we;
    } ctrl_t;
endpackage

// File: rtl/smmw_decode.sv
module smmw_decode
    import smmw_pkg::*;
(
    input  logic [31:0] insn,
    input  logic        cond_ok,
    output ctrl_t       ctrl
);
    logic unused_insn_bits;
    assign unused_insn_bits = ^{insn[27:20], insn[11:7], insn[4:0]} ^ insn[5];

    always_comb begin
        ctrl            = '0;
        ctrl.rd         = insn[19:16];
        ctrl.accumulate = (insn[15:12] != NO_ACC_IDX);
        ctrl.subtract   = insn[6];
        ctrl.round      = insn[5];
        ctrl.we         = (insn[31:28] == COND_ALWAYS) || cond_ok;
    end
endmodule

// File: rtl/smmw_mul_stage.sv
module smmw_mul_stage
    import smmw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic           take,
    input  logic [W-1:0]   mcand,
    input  logic [W-1:0]   mplier,
    input  logic [W-1:0]   acc,
    input  ctrl_t          ctrl,
    output logic           valid_q,
    output logic [2*W-1:0] prod_q,
    output logic [W-1:0]   acc_q,
    output ctrl_t          ctrl_q
);
    localparam int PW = 2 * W;

    typedef struct packed {
        logic          valid;
        logic [PW-1:0] prod;
        logic [W-1:0]  acc;
        ctrl_t         ctrl;
    } st_t;

    st_t cur_q, nxt_d;
    logic signed [PW-1:0] prod_full;

    assign prod_full = $signed(mcand) * $signed(mplier);

    always_comb begin
        nxt_d = cur_q;
        if (advance) begin
            nxt_d.valid = take;
            if (take) begin
                nxt_d.prod = prod_full;
                nxt_d.acc  = acc;
                nxt_d.ctrl = ctrl;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign valid_q = cur_q.valid;
    assign prod_q  = cur_q.prod;
    assign acc_q   = cur_q.acc;
    assign ctrl_q  = cur_q.ctrl;

    // R8: an accepted request occupies this stage on the next cycle
    assert_stage_fill_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && take) |=> valid_q);
endmodule

// File: rtl/smmw_acc_stage.sv
module smmw_acc_stage
    import smmw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           advance,
    input  logic           valid,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   acc,
    input  ctrl_t          ctrl,
    output logic           valid_q,
    output logic [W-1:0]   data_q,
    output logic [3:0]     rd_q,
    output logic           we_q
);
    localparam int PW = 2 * W;
    localparam logic [PW-1:0] ROUND_K = PW'(1) << (W - 1);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] data;
        logic [3:0]   rd;
        logic         we;
    } st_t;

    st_t cur_q, nxt_d;
    logic [PW-1:0] hi_acc;
    logic [PW-1:0] mix;
    logic [W-1:0]  unused_low;

    always_comb begin
        hi_acc = {acc, {W{1'b0}}};
        if (!ctrl.accumulate) begin
            mix = prod;
        end else if (ctrl.subtract) begin
            mix = hi_acc - prod;
        end else begin
            mix = hi_acc + prod;
        end
        if (ctrl.round) begin
            mix = mix + ROUND_K;
        end
        unused_low = mix[W-1:0];

        nxt_d = cur_q;
        if (advance) begin
            nxt_d.valid = valid;
            if (valid) begin
                nxt_d.data = mix[PW-1:W];
                nxt_d.rd   = ctrl.rd;
                nxt_d.we   = ctrl.we;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign valid_q = cur_q.valid;
    assign data_q  = cur_q.data;
    assign rd_q    = cur_q.rd;
    assign we_q    = cur_q.we;

    // R8: a first-stage entry moves to the output when the pipe advances
    assert_stage_drain_R8: assert property (@(posedge clk) disable iff (rst)
        (advance && valid) |=> valid_q);
endmodule

// File: rtl/smmw_mac.sv
module smmw_mac
    import smmw_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [31:0]  in_insn,
    input  logic [W-1:0] in_mcand,
    input  logic [W-1:0] in_mplier,
    input  logic [W-1:0] in_acc,
    input  logic         in_cond_ok,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data,
    output logic [3:0]   out_rd,
    output logic         out_we
);
    ctrl_t          dec_ctrl;
    ctrl_t          s1_ctrl;
    logic           s1_valid;
    logic [2*W-1:0] s1_prod;
    logic [W-1:0]   s1_acc;
    logic           advance;
    logic           take;

    assign advance  = !out_valid || out_ready;
    assign in_ready = advance;
    assign take     = in_valid && advance;

    smmw_decode u_dec (
        .insn    (in_insn),
        .cond_ok (in_cond_ok),
        .ctrl    (dec_ctrl)
    );

    smmw_mul_stage #(.W(W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .take    (take),
        .mcand   (in_mcand),
        .mplier  (in_mplier),
        .acc     (in_acc),
        .ctrl    (dec_ctrl),
        .valid_q (s1_valid),
        .prod_q  (s1_prod),
        .acc_q   (s1_acc),
        .ctrl_q  (s1_ctrl)
    );

    smmw_acc_stage #(.W(W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .valid   (s1_valid),
        .prod    (s1_prod),
        .acc     (s1_acc),
        .ctrl    (s1_ctrl),
        .valid_q (out_valid),
        .data_q  (out_data),
        .rd_q    (out_rd),
        .we_q    (out_we)
    );

    // R1: reset empties the output stage
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R9: a stalled result stays put
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_rd) && $stable(out_we)));

    // R9: no request is taken while the output is blocked
    assert_stall_block_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R7: unconditional requests always carry write permission
    assert_always_writes_R7: assert property (@(posedge clk) disable iff (rst)
        (take && in_insn[31:28] == COND_ALWAYS) |=> s1_ctrl.we);

    // R6: the destination index is taken from the request
    assert_dest_index_R6: assert property (@(posedge clk) disable iff (rst)
        take |=> (s1_ctrl.rd == $past(in_insn[19:16])));
endmodule

// File: tb/smmw_mac_test.sv
`timescale 1ns/1ps
module smmw_mac_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_insn = '0;
    logic [31:0] in_mcand = '0;
    logic [31:0] in_mplier = '0;
    logic [31:0] in_acc = '0;
    logic        in_cond_ok = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic [3:0]  out_rd;
    logic        out_we;

    int total = 0;
    int bad = 0;
    logic [31:0] vals [8];

    always #4 clk = ~clk;

    smmw_mac uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_insn(in_insn), .in_mcand(in_mcand), .in_mplier(in_mplier),
        .in_acc(in_acc), .in_cond_ok(in_cond_ok), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_rd(out_rd), .out_we(out_we)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model(input logic [31:0] insn, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c);
        logic [63:0] p, r;
        p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        if (insn[15:12] == 4'hF)   r = p;
        else if (insn[6])          r = {c, 32'h0} - p;
        else                       r = {c, 32'h0} + p;
        if (insn[5]) r = r + 64'h8000_0000;
        return r[63:32];
    endfunction

    function automatic logic [31:0] mk(input logic [3:0] cond, input logic [3:0] rd,
                                       input logic [3:0] ra, input logic sub, input logic rnd);
        return {cond, 8'h07, rd, ra, 4'h3, 1'b0, sub, rnd, 1'b1, 4'h2};
    endfunction

    task automatic run_one(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] c, input logic ok, input string tag);
        logic exp_we;
        exp_we = (insn[31:28] == 4'hE) || ok;
        @(negedge clk);
        in_valid = 1'b1; in_insn = insn; in_mcand = a; in_mplier = b; in_acc = c; in_cond_ok = ok;
        chk("R9 in_ready idle", 64'(in_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_acc = ~c; in_cond_ok = ~ok;
        chk("R8 not after one edge", 64'(out_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 valid after two edges", 64'(out_valid), 64'd1);
        chk(tag, 64'(out_data), 64'(model(insn, a, b, c)));
        chk("R6 dest index", 64'(out_rd), 64'(insn[19:16]));
        chk("R7 write enable", 64'(out_we), 64'(exp_we));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] ia, ib, ic, e1, e2, e3;
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'h1234_5678;
        vals[6] = 32'hC0DE_F00D; vals[7] = 32'h0001_8000;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears valid", 64'(out_valid), 64'd0);

        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                for (int m = 0; m < 16; m++) begin
                    logic [3:0] ra, cond;
                    string tag;
                    ra   = m[0] ? 4'hF : 4'(i + j + 2);
                    if (ra == 4'hF && !m[0]) ra = 4'h4;
                    cond = m[3] ? 4'hE : 4'(m[1] ? 4'h0 : 4'hB);
                    if (m[0])      tag = "R2 multiply only";
                    else if (m[1]) tag = "R4 subtract";
                    else           tag = "R3 accumulate";
                    if (m[2])      tag = {tag, " R5 rounded"};
                    run_one(mk(cond, 4'(i * 3 + j + m), ra, m[1], m[2]),
                            vals[i], vals[j], vals[(i + 3 * j + m) % 8], ((i + j) % 2) == 1, tag);
                end
            end
        end

        // R5 boundary: rounding carry crosses into the upper word
        run_one(mk(4'hE, 4'h9, 4'hF, 1'b0, 1'b1), 32'h0000_8000, 32'h0001_0000, 32'h0, 1'b0,
                "R5 round carry");
        // R4 operand order: acc<<32 minus product
        run_one(mk(4'hE, 4'h1, 4'h2, 1'b1, 1'b0), 32'h0000_0002, 32'h8000_0000, 32'h0000_0005, 1'b1,
                "R4 order");

        // R9 stall sequence with three requests
        ia = model(mk(4'hE, 4'h1, 4'h2, 1'b0, 1'b0), 32'h10, 32'h7000_0000, 32'h3);
        ib = model(mk(4'hE, 4'h2, 4'h2, 1'b1, 1'b1), 32'hFFFF_FFF0, 32'h2000_0000, 32'h8);
        ic = model(mk(4'hE, 4'h3, 4'hF, 1'b0, 1'b0), 32'h8000_0000, 32'h8000_0000, 32'h0);
        e1 = ia; e2 = ib; e3 = ic;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_insn = mk(4'hE, 4'h1, 4'h2, 1'b0, 1'b0);
        in_mcand = 32'h10; in_mplier = 32'h7000_0000; in_acc = 32'h3;
        @(posedge clk);
        @(negedge clk);
        in_insn = mk(4'hE, 4'h2, 4'h2, 1'b1, 1'b1);
        in_mcand = 32'hFFFF_FFF0; in_mplier = 32'h2000_0000; in_acc = 32'h8;
        @(posedge clk);
        @(negedge clk);
        in_insn = mk(4'hE, 4'h3, 4'hF, 1'b0, 1'b0);
        in_mcand = 32'h8000_0000; in_mplier = 32'h8000_0000; in_acc = 32'h0;
        chk("R9 in_ready low under stall", 64'(in_ready), 64'd0);
        chk("R9 first result shown", 64'(out_data), 64'(e1));
        @(posedge clk);
        @(negedge clk);
        chk("R9 held valid", 64'(out_valid), 64'd1);
        chk("R9 held data", 64'(out_data), 64'(e1));
        chk("R9 held index", 64'(out_rd), 64'd1);
        out_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 second in order", 64'(out_data), 64'(e2));
        chk("R9 second index", 64'(out_rd), 64'd2);
        @(posedge clk);
        @(negedge clk);
        chk("R9 third in order", 64'(out_data), 64'(e3));
        chk("R9 third index", 64'(out_rd), 64'd3);
        @(posedge clk);
        @(negedge clk);
        chk("R9 drained", 64'(out_valid), 64'd0);

        // R1 reset mid-flight
        in_valid = 1'b1; in_insn = mk(4'hE, 4'h5, 4'hF, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset flushes pipe", 64'(out_valid), 64'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 nothing emerges after reset", 64'(out_valid), 64'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule